// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Mode-Driven Pin Routing

This block moves one byte at a time through a single shift register, most significant bit first. A parallel byte is loaded at the start of a transfer and the received byte is presented on a parallel output when the transfer ends. Two data pins, A and B, each with separate out, output-enable and in signals, are attached to the shift register. Three configuration bits decide which pin carries each direction: `cfgMaster` (1 = clock master), `cfgBidir` (1 = one-pin bidirectional) and `cfgClkSync` (1 = clock-synchronous mode, fixed routing). A serial clock pin is driven from an internal divider when the block is master and is sampled through a two-flop synchronizer when it is slave.

A transfer begins when `start` is pulsed while at least one of `txEn` or `rxEn` is set. As master, the block produces exactly eight clock pulses. The clock idles high, output data changes on each falling edge, and input data is sampled on each rising edge. As slave, the block reacts to the synchronized edges of the external clock in the same way. After the eighth sample, `done` pulses for one cycle.

Top module: `sync_serial_port`

## Requirements
- R1: With cfgClkSync=0, cfgBidir=0, cfgMaster=1, transmit data leaves on pin A (ioAOe=1 when txEn=1) and receive data is taken from ioBIn; ioBOe stays 0.
- R2: With cfgClkSync=0, cfgBidir=0, cfgMaster=0, the roles swap: transmit data leaves on pin B (ioBOe=1 when txEn=1) and receive data is taken from ioAIn; ioAOe stays 0.
- R3: With cfgBidir=1 and cfgClkSync=0, transmit uses pin A. If txEn and rxEn are both 1, only transmit happens: ioAOe=1 and rxData keeps its previous value after the byte.
- R4: With cfgBidir=1, cfgClkSync=0, txEn=0 and rxEn=1, ioAOe=0 and the byte is received from ioAIn, in master and in slave mode alike.
- R5: With cfgClkSync=1, transmit is on pin A and receive is from ioBIn, whatever the value of cfgMaster.
- R6: sckOe equals cfgMaster. Whenever no transfer is in progress, sckOut is 1.
- R7: As master, a transfer produces exactly 8 pulses on sckOut, with consecutive falling edges DIV_RATIO clock cycles apart. sckOut does not toggle outside a transfer.
- R8: Bits are shifted most significant first. Output data changes on falling serial-clock edges and input data is captured on rising edges.
- R9: As slave, shifting follows the synchronized edges of sckIn. done stays 0 until the eighth rising edge of sckIn has been seen.
- R10: done is high for exactly one cycle per byte and busy is 0 in that cycle. In that same cycle rxData already holds the received byte, when receive is active.
- R11: A pin that is not the active transmit pin has its output enable at 0, and ioAOe and ioBOe are never 1 together.
- R12: After reset, rxData=0, done=0, busy=0 and sckOut=1. A reset applied during a transfer aborts it.
- R13: A start pulse while txEn=0 and rxEn=0 is ignored: busy stays 0 and sckOut does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMaster | input | 1 | 1 = generate the serial clock, 0 = accept it |
| cfgBidir | input | 1 | 1 = both directions on pin A |
| cfgClkSync | input | 1 | 1 = clock-synchronous mode, fixed routing |
| txEn | input | 1 | Transmit enable |
| rxEn | input | 1 | Receive enable |
| start | input | 1 | Begin (master) or arm (slave) one byte transfer |
| txData | input | BITS | Byte loaded into the shift register at start |
| rxData | output | BITS | Last received byte |
| done | output | 1 | One-cycle end-of-byte pulse |
| busy | output | 1 | Transfer in progress |
| sckOut | output | 1 | Generated serial clock |
| sckOe | output | 1 | Serial clock pin output enable |
| sckIn | input | 1 | External serial clock |
| ioAOut | output | 1 | Data pin A output value |
| ioAOe | output | 1 | Data pin A output enable |
| ioAIn | input | 1 | Data pin A input value |
| ioBOut | output | 1 | Data pin B output value |
| ioBOe | output | 1 | Data pin B output enable |
| ioBIn | input | 1 | Data pin B input value |

## Verification
In bidirectional mode with both enables set, a transmit and a receive would fall on pin A in the same cycles, and the block must let transmit win. The bench provokes this by setting both enables while a peer drives a known pattern into ioAIn. It judges the outcome on three points: the transmitted byte appears on pin A, ioAOe stays high, and rxData still holds the earlier byte when done pulses. A second coincidence is the last rising serial-clock edge and the end of the byte. Here the bench checks that done, the cleared busy and the new rxData all appear in one sampled cycle.

// File: rtl/sserial_pkg.sv
package sserial_pkg;

  // Strobes issued by the control path to the datapath, one cycle each.
  typedef struct packed {
    logic load;    // copy parallel byte into the shift register
    logic drive;   // present next output bit (falling serial edge)
    logic sample;  // capture input bit and shift (rising serial edge)
    logic finish;  // this sample completes the byte
  } sserial_strobe_t;

  typedef enum logic [1:0] {
    PIN_NONE = 2'd0,
    PIN_A    = 2'd1,
    PIN_B    = 2'd2
  } sserial_pin_e;

endpackage

// File: rtl/sserial_pinroute.sv
module sserial_pinroute
  import sserial_pkg::*;
(
  input  logic cfgMaster,
  input  logic cfgBidir,
  input  logic cfgClkSync,
  input  logic txEn,
  input  logic rxEn,
  input  logic txBit,
  input  logic ioAIn,
  input  logic ioBIn,
  output logic ioAOut,
  output logic ioAOe,
  output logic ioBOut,
  output logic ioBOe,
  output logic rxBit,
  output logic rxActive
);

  logic bidirEff;
  logic swapped;
  logic txActive;
  sserial_pin_e txPin;
  sserial_pin_e rxPin;

  always_comb begin
    // Clock-synchronous select overrides both other routing bits.
    bidirEff = cfgBidir & ~cfgClkSync;
    swapped  = ~cfgClkSync & ~cfgBidir & ~cfgMaster;

    // Half-duplex rule: in one-pin mode transmit wins over receive.
    txActive = txEn;
    rxActive = rxEn & ~(bidirEff & txEn);

    txPin = swapped ? PIN_B : PIN_A;
    rxPin = (bidirEff | swapped) ? PIN_A : PIN_B;
    if (!txActive) txPin = PIN_NONE;
    if (!rxActive) rxPin = PIN_NONE;

    ioAOe  = (txPin == PIN_A);
    ioBOe  = (txPin == PIN_B);
    ioAOut = ioAOe & txBit;
    ioBOut = ioBOe & txBit;

    unique case (rxPin)
      PIN_A:   rxBit = ioAIn;
      PIN_B:   rxBit = ioBIn;
      default: rxBit = 1'b0;
    endcase
  end

endmodule

// File: rtl/sserial_ctrl.sv
module sserial_ctrl
  import sserial_pkg::*;
#(
  parameter int DIV_RATIO = 4,
  parameter int BITS      = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgMaster,
  input  logic            start,
  input  logic            anyEn,
  input  logic            sckIn,
  output sserial_strobe_t strobe,
  output logic            sckGen,
  output logic            busy,
  output logic            done
);

  localparam int HALF = (DIV_RATIO / 2 < 1) ? 1 : DIV_RATIO / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BCW  = $clog2(BITS + 1);
  localparam logic [CW-1:0]  HALF_END = CW'(HALF - 1);
  localparam logic [BCW-1:0] BIT_END  = BCW'(BITS - 1);

  logic [CW-1:0]  divCnt;
  logic [BCW-1:0] bitCnt;
  logic sckS1, sckS2, sckS3;
  logic halfTick, slvFall, slvRise;

  always_comb begin
    halfTick = busy & cfgMaster & (divCnt == HALF_END);
    slvFall  = busy & ~cfgMaster & sckS3 & ~sckS2;
    slvRise  = busy & ~cfgMaster & ~sckS3 & sckS2;

    strobe.load   = ~busy & start & anyEn;
    strobe.drive  = (halfTick & sckGen) | slvFall;
    strobe.sample = (halfTick & ~sckGen) | slvRise;
    strobe.finish = strobe.sample & (bitCnt == BIT_END);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS1  <= 1'b1;
      sckS2  <= 1'b1;
      sckS3  <= 1'b1;
      sckGen <= 1'b1;
      divCnt <= '0;
      bitCnt <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      sckS1 <= sckIn;
      sckS2 <= sckS1;
      sckS3 <= sckS2;
      done  <= 1'b0;
      if (!busy) begin
        sckGen <= 1'b1;
        divCnt <= '0;
        bitCnt <= '0;
        if (strobe.load) busy <= 1'b1;
      end else begin
        if (cfgMaster) begin
          if (halfTick) begin
            divCnt <= '0;
            sckGen <= ~sckGen;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        if (strobe.sample) begin
          bitCnt <= bitCnt + 1'b1;
          if (strobe.finish) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sserial_datapath.sv
module sserial_datapath
  import sserial_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  sserial_strobe_t strobe,
  input  logic [BITS-1:0] txData,
  input  logic            rxBit,
  input  logic            rxActive,
  output logic            txBit,
  output logic [BITS-1:0] rxData
);

  logic [BITS-1:0] shiftReg;
  logic [BITS-1:0] shiftNext;

  always_comb shiftNext = {shiftReg[BITS-2:0], rxBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      txBit    <= 1'b0;
      rxData   <= '0;
    end else begin
      if (strobe.load)   shiftReg <= txData;
      if (strobe.drive)  txBit    <= shiftReg[BITS-1];
      if (strobe.sample) shiftReg <= shiftNext;
      if (strobe.finish && rxActive) rxData <= shiftNext;
    end
  end

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import sserial_pkg::*;
#(
  parameter int DIV_RATIO = 4,
  parameter int BITS      = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgMaster,
  input  logic            cfgBidir,
  input  logic            cfgClkSync,
  input  logic            txEn,
  input  logic            rxEn,
  input  logic            start,
  input  logic [BITS-1:0] txData,
  output logic [BITS-1:0] rxData,
  output logic            done,
  output logic            busy,
  output logic            sckOut,
  output logic            sckOe,
  input  logic            sckIn,
  output logic            ioAOut,
  output logic            ioAOe,
  input  logic            ioAIn,
  output logic            ioBOut,
  output logic            ioBOe,
  input  logic            ioBIn
);

  sserial_strobe_t strobe;
  logic txBit;
  logic rxBit;
  logic rxActive;
  logic sckGen;

  sserial_ctrl #(.DIV_RATIO(DIV_RATIO), .BITS(BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .start(start),
    .anyEn(txEn | rxEn), .sckIn(sckIn), .strobe(strobe),
    .sckGen(sckGen), .busy(busy), .done(done)
  );

  sserial_datapath #(.BITS(BITS)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .rxBit(rxBit), .rxActive(rxActive), .txBit(txBit), .rxData(rxData)
  );

  sserial_pinroute u_route (
    .cfgMaster(cfgMaster), .cfgBidir(cfgBidir), .cfgClkSync(cfgClkSync),
    .txEn(txEn), .rxEn(rxEn), .txBit(txBit), .ioAIn(ioAIn), .ioBIn(ioBIn),
    .ioAOut(ioAOut), .ioAOe(ioAOe), .ioBOut(ioBOut), .ioBOe(ioBOe),
    .rxBit(rxBit), .rxActive(rxActive)
  );

  assign sckOut = sckGen;
  assign sckOe  = cfgMaster;

endmodule

// File: rtl/sserial_checker.sv
module sserial_checker (
  input logic clk,
  input logic rstN,
  input logic cfgMaster,
  input logic busy,
  input logic done,
  input logic sckOut,
  input logic ioAOe,
  input logic ioBOe
);

  logic [4:0] riseCnt;
  logic       sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt <= '0;
      sckPrev <= 1'b1;
    end else begin
      sckPrev <= sckOut;
      if (!busy) riseCnt <= '0;
      else if (sckOut && !sckPrev) riseCnt <= riseCnt + 1'b1;
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sckOut);

  assert_sck_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sckOut) |-> $past(busy));

  assert_pulse_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && cfgMaster) |-> ($rose(sckOut) && riseCnt == 5'd7));

  assert_oe_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(ioAOe && ioBOe));

endmodule

bind sync_serial_port sserial_checker u_checker (
  .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .busy(busy), .done(done),
  .sckOut(sckOut), .ioAOe(ioAOe), .ioBOe(ioBOe)
);

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;

  localparam int DIV = 4;
  localparam int NV  = 9;

  // {master, bidir, clkSync, txEn, rxEn, txByte, peerByte, txPin, rxPin}
  // pin code: 0 = none, 1 = pin A, 2 = pin B
  localparam logic [24:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b1,1'b1, 8'hA5, 8'h3C, 2'd1, 2'd2},
    {1'b0,1'b0,1'b0,1'b1,1'b1, 8'h96, 8'hC3, 2'd2, 2'd1},
    {1'b1,1'b1,1'b0,1'b1,1'b1, 8'h5A, 8'hFF, 2'd1, 2'd0},
    {1'b1,1'b1,1'b0,1'b0,1'b1, 8'h00, 8'h81, 2'd0, 2'd1},
    {1'b0,1'b1,1'b0,1'b1,1'b0, 8'hE7, 8'h00, 2'd1, 2'd0},
    {1'b0,1'b1,1'b0,1'b0,1'b1, 8'h00, 8'h6D, 2'd0, 2'd1},
    {1'b1,1'b0,1'b1,1'b1,1'b1, 8'h12, 8'hEF, 2'd1, 2'd2},
    {1'b0,1'b0,1'b1,1'b1,1'b1, 8'h80, 8'h01, 2'd1, 2'd2},
    {1'b1,1'b0,1'b0,1'b1,1'b0, 8'h7E, 8'h55, 2'd1, 2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMaster = 1'b1, cfgBidir = 1'b0, cfgClkSync = 1'b0;
  logic txEn = 1'b0, rxEn = 1'b0, start = 1'b0;
  logic [7:0] txData = 8'h00;
  logic [7:0] rxData;
  logic done, busy, sckOut, sckOe;
  logic sckIn = 1'b1;
  logic ioAOut, ioAOe, ioBOut, ioBOe;
  logic ioAIn = 1'b0, ioBIn = 1'b0;

  int errors = 0;
  int checks = 0;
  int doneSeen;
  logic [7:0] rxAtDone;
  logic [7:0] capByte;
  int pulses;
  int fallGap;

  always #10 clk = ~clk;

  sync_serial_port #(.DIV_RATIO(DIV), .BITS(8)) dut (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgBidir(cfgBidir),
    .cfgClkSync(cfgClkSync), .txEn(txEn), .rxEn(rxEn), .start(start),
    .txData(txData), .rxData(rxData), .done(done), .busy(busy),
    .sckOut(sckOut), .sckOe(sckOe), .sckIn(sckIn),
    .ioAOut(ioAOut), .ioAOe(ioAOe), .ioAIn(ioAIn),
    .ioBOut(ioBOut), .ioBOe(ioBOe), .ioBIn(ioBIn)
  );

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (done) begin
      doneSeen++;
      rxAtDone = rxData;
      chk(!busy, "R10 busy low with done", busy, 0);
    end
  endtask

  task automatic drivePeer(input logic b, input int rxPin);
    ioAIn = (rxPin == 2) ? ~b : b;
    ioBIn = (rxPin == 2) ? b : ~b;
  endtask

  function automatic logic txPinVal(input int txPin);
    return (txPin == 2) ? ioBOut : ioAOut;
  endfunction

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runMaster(input logic [7:0] peer, input int txPin, input int rxPin);
    logic prev;
    int idx;
    int cyc;
    int firstFall;
    prev = 1'b1; idx = 0; cyc = 0; firstFall = -1;
    pulses = 0; fallGap = 0; capByte = '0; doneSeen = 0;
    pulseStart();
    while (doneSeen == 0 && cyc < 400) begin
      tick();
      cyc++;
      if (prev && !sckOut) begin
        if (firstFall < 0) firstFall = cyc;
        else if (fallGap == 0) fallGap = cyc - firstFall;
        if (idx < 8) drivePeer(peer[7 - idx], rxPin);
        idx++;
      end
      if (!prev && sckOut) begin
        pulses++;
        capByte = {capByte[6:0], txPinVal(txPin)};
      end
      prev = sckOut;
    end
    repeat (4) begin
      tick();
      if (!prev && sckOut) pulses++;
      prev = sckOut;
    end
  endtask

  task automatic runSlave(input logic [7:0] peer, input int txPin, input int rxPin);
    capByte = '0; doneSeen = 0;
    pulseStart();
    for (int i = 0; i < 8; i++) begin
      sckIn = 1'b0;
      drivePeer(peer[7 - i], rxPin);
      repeat (8) tick();
      capByte = {capByte[6:0], txPinVal(txPin)};
      if (i == 7) chk(doneSeen == 0, "R9 no done before last edge", doneSeen, 0);
      sckIn = 1'b1;
      repeat (8) tick();
    end
    repeat (4) tick();
  endtask

  initial begin
    logic [7:0] lastRx;
    lastRx = 8'h00;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(rxData == 8'h00, "R12 rxData after reset", rxData, 0);
    chk(done == 1'b0, "R12 done after reset", done, 0);
    chk(busy == 1'b0, "R12 busy after reset", busy, 0);
    chk(sckOut == 1'b1, "R12 sckOut after reset", sckOut, 1);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [24:0] e;
      int txPin, rxPin;
      string tag;
      e = VEC[v];
      cfgMaster = e[24]; cfgBidir = e[23]; cfgClkSync = e[22];
      txEn = e[21]; rxEn = e[20]; txData = e[19:12];
      txPin = int'(e[3:2]); rxPin = int'(e[1:0]);
      tag = e[22] ? "R5" : e[23] ? (e[21] ? "R3" : "R4") : (e[24] ? "R1" : "R2");
      @(negedge clk);
      chk(ioAOe == (txPin == 1), {tag, " R11 pin A enable"}, ioAOe, txPin == 1);
      chk(ioBOe == (txPin == 2), {tag, " R11 pin B enable"}, ioBOe, txPin == 2);
      chk(sckOe == e[24], "R6 clock pin direction", sckOe, e[24]);
      if (e[24]) runMaster(e[11:4], txPin, rxPin);
      else runSlave(e[11:4], txPin, rxPin);
      if (e[24]) begin
        chk(pulses == 8, "R7 pulse count", pulses, 8);
        chk(fallGap == DIV, "R7 falling edge spacing", fallGap, DIV);
      end
      chk(doneSeen == 1, "R10 single done pulse", doneSeen, 1);
      if (txPin != 0)
        chk(capByte == e[19:12], {tag, e[24] ? " R8" : " R9", " transmitted byte"},
            capByte, e[19:12]);
      if (rxPin != 0) lastRx = e[11:4];
      chk(rxAtDone == lastRx, {tag, " R10 rxData at done"}, rxAtDone, lastRx);
      chk(rxData == lastRx, {tag, " rxData after byte"}, rxData, lastRx);
      chk(sckOut == 1'b1, "R6 clock idle high", sckOut, 1);
    end

    // R13: start with both enables off is ignored
    cfgMaster = 1'b1; cfgBidir = 1'b0; cfgClkSync = 1'b0;
    txEn = 1'b0; rxEn = 1'b0;
    @(negedge clk);
    chk(!ioAOe && !ioBOe, "R11 no enable without txEn", {ioAOe, ioBOe}, 0);
    pulseStart();
    begin
      int toggles;
      toggles = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (busy || !sckOut) toggles++;
      end
      chk(toggles == 0, "R13 start ignored", toggles, 0);
    end

    // R12: reset in the middle of a master transfer
    txEn = 1'b1; rxEn = 1'b1; txData = 8'hC9;
    pulseStart();
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R12 transfer running before reset", busy, 1);
    rstN = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && sckOut == 1'b1 && rxData == 8'h00,
        "R12 abort on reset", {busy, sckOut, rxData}, 10'h100);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R12 stays idle after abort", {done, busy}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule